// File: doc/BRIEF.md
# Signed Fractional Gain Trim

This block corrects the gain of a stream of signed 20-bit converter samples. A 12-bit two's complement trim word is held in a register. Each accepted sample is multiplied by a factor of one plus the trim divided by 4096, so the correction covers roughly half to one and a half times unity. The full-precision product is shifted right arithmetically, which rounds toward negative infinity. The result is clamped to the 20-bit signed range.

Samples enter on a valid/data pair and leave on a valid/data pair a fixed two cycles later. The trim register is loaded through a one-cycle write strobe. A new trim value governs the samples presented after the write cycle. A sample that is already accepted, or that arrives in the same cycle as the write, keeps the value that was in force when it entered.

Top module: `gain_trim`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `out_valid_o` is 0 and `out_data_o` is 0. The trim register is cleared, so the first samples pass at unity gain.
- R2: For a valid sample x and a trim register value g, read as a signed 12-bit number, the output is floor(x·(4096+g)/4096), clamped as in R6 and R7.
- R3: With g = 000h, every sample passes through unchanged.
- R4: With g = 7FFh, the output is floor(x·6143/4096), about 1.5 times the input.
- R5: With g = 801h, the output is floor(x·2049/4096), about 0.5 times the input. With g = 800h, it is exactly floor(x/2).
- R6: A result above 524287 is output as 524287.
- R7: A result below −524288 is output as −524288.
- R8: A sample presented with `in_valid_i` high in cycle t appears in cycle t+2 with `out_valid_o` high. `out_valid_o` is low in every cycle whose input two cycles earlier was not valid.
- R9: A write with `trim_we_i` high in cycle t applies to samples presented in cycle t+1 and later. A sample in cycle t, and any sample already in the pipeline, uses the earlier value.
- R10: `out_data_o` holds its last value while `out_valid_o` is low. Data presented with `in_valid_i` low does not affect the output.
- R11: The output has the same sign as the input sample that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | 20 | Signed input sample |
| trim_we_i | input | 1 | Trim register write strobe |
| trim_data_i | input | 12 | Two's complement trim word |
| out_valid_o | output | 1 | Output sample valid |
| out_data_o | output | 20 | Signed, saturated output sample |

## Verification
Every scaled result is due two clock edges after the cycle in which its sample was presented. The bench keeps a two-deep queue of expected values, one per driven cycle. It checks the front entry one falling edge after the second rising edge, so each comparison looks at the exact cycle the result is due. A trim write updates the bench's model only after the same-cycle sample has taken its expected value, which mirrors the one-cycle boundary of R9. Cycles with no valid input check that the valid output is low and the data is held.

// File: rtl/gain_trim_pkg.sv
package gain_trim_pkg;
  localparam int unsigned DATA_W_DEF = 20;
  localparam int unsigned TRIM_W_DEF = 12;

  // coefficient carries unity plus a signed trim: two extra bits
  function automatic int unsigned coef_width(int unsigned trim_w);
    return trim_w + 2;
  endfunction
endpackage

// File: rtl/gain_trim_coef_reg.sv
module gain_trim_coef_reg #(
  parameter int unsigned TRIM_W = 12,
  parameter int unsigned COEF_W = TRIM_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [TRIM_W-1:0]        trim_i,
  output logic signed [COEF_W-1:0] coef_o
);
  logic signed [TRIM_W-1:0] trim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   trim_q <= '0;
    else if (we_i) trim_q <= trim_i;
  end

  localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(1) <<< TRIM_W;

  assign coef_o = UNITY + COEF_W'(trim_q);
endmodule

// File: rtl/gain_trim_mul_stage.sv
module gain_trim_mul_stage #(
  parameter int unsigned DATA_W = 20,
  parameter int unsigned COEF_W = 14,
  parameter int unsigned PROD_W = DATA_W + COEF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] data_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic                     valid_o,
  output logic signed [PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] prod_d;

  assign prod_d = PROD_W'(data_i) * PROD_W'(coef_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) prod_o <= prod_d;
    end
  end
endmodule

// File: rtl/gain_trim_sat_stage.sv
module gain_trim_sat_stage #(
  parameter int unsigned DATA_W   = 20,
  parameter int unsigned PROD_W   = 34,
  parameter int unsigned SHIFT    = 12,
  parameter bit          SATURATE = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [PROD_W-1:0] prod_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] data_o
);
  localparam int unsigned HI_W = PROD_W - DATA_W + 1;
  localparam logic signed [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [PROD_W-1:0] shifted;
  logic        [HI_W-1:0]   hi_bits;
  logic signed [DATA_W-1:0] res_d;

  // arithmetic shift: floor division by 2^SHIFT
  assign shifted = prod_i >>> SHIFT;
  assign hi_bits = shifted[PROD_W-1:DATA_W-1];

  generate
    if (SATURATE) begin : g_clamp
      always_comb begin
        if (&hi_bits || ~|hi_bits) res_d = shifted[DATA_W-1:0];
        else if (hi_bits[HI_W-1])  res_d = NEG_MIN;
        else                       res_d = POS_MAX;
      end
    end else begin : g_wrap
      assign res_d = shifted[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= res_d;
    end
  end
endmodule

// File: rtl/gain_trim.sv
module gain_trim
  import gain_trim_pkg::*;
#(
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned TRIM_W   = TRIM_W_DEF,
  parameter bit          SATURATE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              trim_we_i,
  input  logic [TRIM_W-1:0] trim_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int unsigned COEF_W = coef_width(TRIM_W);
  localparam int unsigned PROD_W = DATA_W + COEF_W;

  logic signed [COEF_W-1:0] coef;
  logic                     p_valid;
  logic signed [PROD_W-1:0] p_prod;
  logic signed [DATA_W-1:0] res;

  gain_trim_coef_reg #(.TRIM_W(TRIM_W), .COEF_W(COEF_W)) u_coef (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (trim_we_i),
    .trim_i (trim_data_i),
    .coef_o (coef)
  );

  gain_trim_mul_stage #(.DATA_W(DATA_W), .COEF_W(COEF_W), .PROD_W(PROD_W)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .data_i  (in_data_i),
    .coef_i  (coef),
    .valid_o (p_valid),
    .prod_o  (p_prod)
  );

  gain_trim_sat_stage #(
    .DATA_W(DATA_W), .PROD_W(PROD_W), .SHIFT(TRIM_W), .SATURATE(SATURATE)
  ) u_sat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (p_valid),
    .prod_i  (p_prod),
    .valid_o (out_valid_o),
    .data_o  (res)
  );

  assign out_data_o = res;
endmodule

// File: rtl/gain_trim_chk.sv
module gain_trim_chk #(
  parameter int unsigned DATA_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o
);
  logic [1:0] age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_valid_align_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) |-> (out_valid_o == $past(in_valid_i, 2)));

  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age != 2'd0 && !out_valid_o) |-> $stable(out_data_o));

  assert_sign_kept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && out_valid_o) |-> (out_data_o[DATA_W-1] == $past(in_data_i[DATA_W-1], 2)));

  assert_zero_in_zero_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && out_valid_o && $past(in_data_i, 2) == '0) |-> (out_data_o == '0));

  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && out_data_o == '0));
endmodule

bind gain_trim gain_trim_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o)
);

// File: tb/sim_gain_trim.sv
`timescale 1ns/1ps
module sim_gain_trim;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [19:0] in_data_i = '0;
  logic        trim_we_i = 1'b0;
  logic [11:0] trim_data_i = '0;
  logic        out_valid_o;
  logic [19:0] out_data_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i; // 50 MHz

  gain_trim u0 (.*);

  // bench model state
  logic [11:0] cur_trim = '0;
  logic        p0_v = 0, p1_v = 0;
  logic [19:0] p0_d = '0, p1_d = '0;
  string       p0_t = "", p1_t = "";
  logic [19:0] last_out = '0;

  function automatic logic [19:0] model(logic [19:0] x, logic [11:0] g);
    longint p, q;
    p = longint'($signed(x)) * (64'sd4096 + longint'($signed(g)));
    q = p >>> 12;
    if (q > 524287)  q = 524287;
    if (q < -524288) q = -524288;
    return q[19:0];
  endfunction

  function automatic string pick_tag(logic [19:0] x, logic [11:0] g);
    longint p;
    p = (longint'($signed(x)) * (64'sd4096 + longint'($signed(g)))) >>> 12;
    if (p > 524287)  return "R6";
    if (p < -524288) return "R7";
    if (g == 12'h000) return "R3";
    if (g == 12'h7FF) return "R4";
    if (g == 12'h801 || g == 12'h800) return "R5";
    return "R2";
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_out();
    if (p1_v) begin
      check(out_valid_o === 1'b1, "R8", out_valid_o, 1);
      check(out_data_o === p1_d, p1_t, $signed(out_data_o), $signed(p1_d));
      last_out = p1_d;
    end else begin
      check(out_valid_o === 1'b0, "R8", out_valid_o, 0);
      check(out_data_o === last_out, "R10", $signed(out_data_o), $signed(last_out));
    end
  endtask

  // one cycle: check due results, queue expectation, drive inputs
  task automatic cyc(input bit v, input logic [19:0] d, input bit w,
                     input logic [11:0] t, input string tag);
    check_out();
    p1_v = p0_v; p1_d = p0_d; p1_t = p0_t;
    p0_v = v;
    p0_d = model(d, cur_trim);
    p0_t = (tag != "") ? tag : pick_tag(d, cur_trim);
    in_valid_i  = v;
    in_data_i   = d;
    trim_we_i   = w;
    trim_data_i = t;
    if (w) cur_trim = t;
    @(negedge clk_i);
  endtask

  task automatic sweep(input logic [11:0] g);
    cyc(0, 20'h12345, 1, g, "");
    cyc(1, 20'h00000, 0, 0, "");
    cyc(1, 20'h00001, 0, 0, "");
    cyc(1, 20'hFFFFF, 0, 0, "");
    cyc(1, 20'h7FFFF, 0, 0, "");
    cyc(1, 20'h80000, 0, 0, "");
    cyc(1, 20'h55555, 0, 0, "");
    cyc(1, 20'hAAAAB, 0, 0, "");
    for (int xi = -524288; xi < 524288; xi += 16411) begin
      cyc(1, 20'(xi), 0, 0, "");
    end
  endtask

  initial begin
    @(negedge clk_i);
    check(out_valid_o === 1'b0, "R1", out_valid_o, 0);
    check(out_data_o === 20'h0, "R1", out_data_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    check(out_valid_o === 1'b0, "R1", out_valid_o, 0);
    check(out_data_o === 20'h0, "R1", out_data_o, 0);
    // default trim is unity
    cyc(1, 20'h3A5C1, 0, 0, "R1");
    cyc(1, 20'hC0001, 0, 0, "R1");
    cyc(0, 20'h0, 0, 0, "");
    // ignored input data while not valid
    cyc(0, 20'h7FFFF, 0, 0, "R10");
    cyc(0, 20'h80000, 0, 0, "R10");
    cyc(0, 20'h11111, 0, 0, "R10");
    cyc(0, 20'h0, 0, 0, "");
    // named corner trims
    sweep(12'h000);
    sweep(12'h7FF);
    sweep(12'h801);
    sweep(12'h800);
    sweep(12'h001);
    sweep(12'hFFF);
    for (int ti = 0; ti < 4096; ti += 113) sweep(12'(ti));
    // R9: writes between back-to-back samples
    cyc(1, 20'h40000, 1, 12'h000, "R9");
    cyc(1, 20'h40000, 1, 12'h7FF, "R9");
    cyc(1, 20'h40000, 1, 12'h800, "R9");
    cyc(1, 20'h40000, 0, 12'h000, "R9");
    cyc(1, 20'hC0000, 1, 12'h400, "R9");
    cyc(1, 20'hC0000, 0, 12'h000, "R9");
    cyc(0, 20'h0, 0, 0, "");
    cyc(0, 20'h0, 0, 0, "");
    cyc(0, 20'h0, 0, 0, "");
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule